// File: doc/BRIEF.md
# Split-Bank Activation Tracker

This block sits in front of a single memory device that has 32 banks. Neighbouring banks share sense amplifiers, so activating one bank takes both of the amplifiers beside it. Each cycle the controller may present one request: activate a row, read or write a column, or precharge a bank. The tracker answers in the same cycle with an accept flag. It does this by checking the bank's open or closed state, the bank's own elapsed-time counters and whether its neighbours are open.

An accepted request updates that bank's state at the next rising clock edge. A rejected request changes nothing. The tracker also publishes, for every bank, whether a row is open and which row was most recently activated there. The controller can use these outputs to plan its next commands.

The neighbour rule has breaks at the ends and in the middle of the bank array. The amplifiers at both outer edges are private, and so are the two amplifiers on either side of the boundary between bank 15 and bank 16. As a result:
- Bank 0 has no lower neighbour.
- Bank 31 has no upper neighbour.
- Banks 15 and 16 never block each other.

Top module: `sbt_tracker`

## Requirements
- R1: After a synchronous reset every bank is closed and every recorded row is zero. All timings count as already met, so an activate to any bank is accepted in the first cycle after reset.
- R2: An activate (`req_cmd` = 2'b01) is accepted when the target bank is closed, its precharge time has elapsed and neither of its neighbours is open. One cycle later the bank reads as open and its row output holds `req_row`.
- R3: An activate to bank b is rejected while bank b-1 or bank b+1 is open. The exceptions are that bank 0 has no lower neighbour, bank 31 has no upper neighbour, and banks 15 and 16 do not block each other.
- R4: An activate to a bank that is already open is rejected.
- R5: A read (2'b10) or write (2'b11) is accepted only when the bank is open and at least T_RCD cycles have passed since its activate. The activate cycle counts as cycle 0, so the earliest legal cycle is cycle T_RCD. A column request to a closed bank is rejected.
- R6: A precharge (2'b00) is accepted only when the bank is open and at least T_RAS + T_COL_EXTRA × max(0, n − FREE_COLS) cycles have passed since its activate, where n is the number of column requests accepted on that row. A precharge to a closed bank is rejected.
- R7: An activate to a bank is accepted only when at least T_RP cycles have passed since that bank's last precharge. Precharging one bank does not delay activates to any other bank.
- R8: A rejected request, or a cycle with `req_valid` low, leaves every bank's open flag, row and timers unchanged. Each bank's row output holds the last activated row even after that bank is precharged.
- R9: `req_accept` is low whenever `req_valid` is low, and it is driven combinationally in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_cmd | input | 2 | 00 precharge, 01 activate, 10 read, 11 write |
| req_bank | input | 5 | Target bank |
| req_row | input | 9 | Row address for an activate |
| req_accept | output | 1 | Request is legal and takes effect at the next edge |
| bank_open | output | 32 | One bit per bank, set while a row is open |
| bank_row | output | 288 | Last activated row per bank, 9 bits per bank, bank 0 in the low bits |

## Verification
The bench keeps a behavioural model and compares it with the design on every cycle. Directed phases probe each neighbour boundary:
- Activates at banks 0, 15, 16 and 31. A design with the wrong neighbour decode would either lock out a legal bank or let two banks that share an amplifier be open together.
- Column and precharge requests issued every cycle from the activate onwards, so an off-by-one in a counter shows up as an acceptance one cycle early or late.
- More than FREE_COLS column operations on one row, which catches a precharge that ignores the stretched deadline.

A long random phase keeps banks at low indices in conflict, to catch state that a rejected request wrongly changes.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    typedef enum logic [1:0] {
        CMD_PRE  = 2'b00,
        CMD_ACT  = 2'b01,
        CMD_RD   = 2'b10,
        CMD_WR   = 2'b11
    } sbt_cmd_e;

    // Per-bank summary that the decision logic consumes
    typedef struct packed {
        logic is_open;
        logic rcd_met;
        logic ras_met;
        logic rp_met;
    } sbt_bank_view_t;

    // Bank b shares an amplifier with bank b-1 unless it sits at an array edge
    function automatic bit has_lower_peer(input int b, input int half);
        return (b != 0) && (b != half);
    endfunction

    // Bank b shares an amplifier with bank b+1 unless it sits at an array edge
    function automatic bit has_upper_peer(input int b, input int nbanks, input int half);
        return (b != nbanks - 1) && (b != half - 1);
    endfunction

endpackage

// File: rtl/sbt_bank.sv
module sbt_bank
    import sbt_pkg::*;
#(
    parameter int ROW_W       = 9,
    parameter int T_RCD       = 3,
    parameter int T_RAS       = 8,
    parameter int T_RP        = 4,
    parameter int T_COL_EXTRA = 2,
    parameter int FREE_COLS   = 4,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_fire,
    input  logic             col_fire,
    input  logic             pre_fire,
    input  logic [ROW_W-1:0] row_in,
    output sbt_bank_view_t   view,
    output logic [ROW_W-1:0] row_q
);

    localparam int COL_W = $clog2(FREE_COLS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             open_q;
    logic [CNT_W-1:0] act_age;
    logic [CNT_W-1:0] pre_age;
    logic [CNT_W-1:0] ras_need;
    logic [COL_W-1:0] col_cnt;
    logic [CNT_W:0]   need_sum;

    assign need_sum = {1'b0, ras_need} + (CNT_W+1)'(T_COL_EXTRA);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q   <= 1'b0;
            row_q    <= '0;
            act_age  <= CNT_MAX;
            pre_age  <= CNT_MAX;
            ras_need <= CNT_W'(T_RAS);
            col_cnt  <= '0;
        end else begin
            // Elapsed-time counters saturate so old events stay "met"
            if (act_fire) begin
                act_age <= CNT_W'(1);
            end else if (act_age != CNT_MAX) begin
                act_age <= act_age + 1'b1;
            end

            if (pre_fire) begin
                pre_age <= CNT_W'(1);
            end else if (pre_age != CNT_MAX) begin
                pre_age <= pre_age + 1'b1;
            end

            if (act_fire) begin
                open_q   <= 1'b1;
                row_q    <= row_in;
                ras_need <= CNT_W'(T_RAS);
                col_cnt  <= '0;
            end else if (pre_fire) begin
                open_q <= 1'b0;
            end else if (col_fire) begin
                if (col_cnt == COL_W'(FREE_COLS)) begin
                    ras_need <= need_sum[CNT_W] ? CNT_MAX : need_sum[CNT_W-1:0];
                end else begin
                    col_cnt <= col_cnt + 1'b1;
                end
            end
        end
    end

    always_comb begin
        view.is_open = open_q;
        view.rcd_met = act_age >= CNT_W'(T_RCD);
        view.ras_met = act_age >= ras_need;
        view.rp_met  = pre_age >= CNT_W'(T_RP);
    end

    // R5: a column command only fires on an open row old enough for it
    a_r5_col_on_ready_row: assert property (@(posedge clk) disable iff (rst)
        col_fire |-> (open_q && act_age >= CNT_W'(T_RCD)));

    // R6: a precharge only fires on an open bank
    a_r6_pre_on_open: assert property (@(posedge clk) disable iff (rst)
        pre_fire |-> open_q);

    // R6: a precharge closes the bank
    a_r6_pre_closes: assert property (@(posedge clk) disable iff (rst)
        pre_fire |=> !open_q);

    // R7: an activate respects the precharge time
    a_r7_act_after_rp: assert property (@(posedge clk) disable iff (rst)
        act_fire |-> (!open_q && pre_age >= CNT_W'(T_RP)));

    // R2: an activate opens the bank with the requested row
    a_r2_act_records_row: assert property (@(posedge clk) disable iff (rst)
        act_fire |=> (open_q && row_q == $past(row_in)));

endmodule

// File: rtl/sbt_rules.sv
module sbt_rules
    import sbt_pkg::*;
#(
    parameter int NUM_BANKS = 32,
    parameter int BANK_W    = 5
) (
    input  logic                            req_valid,
    input  sbt_cmd_e                        req_cmd,
    input  logic [BANK_W-1:0]               req_bank,
    input  sbt_bank_view_t [NUM_BANKS-1:0]  views,
    output logic                            req_accept,
    output logic [NUM_BANKS-1:0]            act_fire,
    output logic [NUM_BANKS-1:0]            col_fire,
    output logic [NUM_BANKS-1:0]            pre_fire
);

    localparam int HALF = NUM_BANKS / 2;

    logic [NUM_BANKS-1:0] peer_busy;

    for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_peer
        logic lo_busy;
        logic hi_busy;
        if (has_lower_peer(gb, HALF)) begin : g_lo
            assign lo_busy = views[gb-1].is_open;
        end else begin : g_no_lo
            assign lo_busy = 1'b0;
        end
        if (has_upper_peer(gb, NUM_BANKS, HALF)) begin : g_hi
            assign hi_busy = views[gb+1].is_open;
        end else begin : g_no_hi
            assign hi_busy = 1'b0;
        end
        assign peer_busy[gb] = lo_busy | hi_busy;
    end

    sbt_bank_view_t sel;
    logic           legal;
    logic           is_act;
    logic           is_col;
    logic           is_pre;

    always_comb begin
        sel    = views[req_bank];
        is_act = (req_cmd == CMD_ACT);
        is_pre = (req_cmd == CMD_PRE);
        is_col = (req_cmd == CMD_RD) || (req_cmd == CMD_WR);
        legal  = 1'b0;
        unique case (req_cmd)
            CMD_ACT: legal = !sel.is_open && sel.rp_met && !peer_busy[req_bank];
            CMD_RD,
            CMD_WR:  legal = sel.is_open && sel.rcd_met;
            CMD_PRE: legal = sel.is_open && sel.ras_met;
            default: legal = 1'b0;
        endcase
        req_accept = req_valid && legal;
    end

    always_comb begin
        for (int i = 0; i < NUM_BANKS; i++) begin
            act_fire[i] = req_accept && is_act && (req_bank == BANK_W'(i));
            col_fire[i] = req_accept && is_col && (req_bank == BANK_W'(i));
            pre_fire[i] = req_accept && is_pre && (req_bank == BANK_W'(i));
        end
    end

    // R9: acceptance never appears without a request
    always_comb begin
        if (!req_valid) begin
            a_r9_accept_needs_valid: assert (!req_accept);
        end
    end

endmodule

// File: rtl/sbt_tracker.sv
module sbt_tracker
    import sbt_pkg::*;
#(
    parameter int NUM_BANKS   = 32,
    parameter int ROW_W       = 9,
    parameter int T_RCD       = 3,
    parameter int T_RAS       = 8,
    parameter int T_RP        = 4,
    parameter int T_COL_EXTRA = 2,
    parameter int FREE_COLS   = 4,
    parameter int CNT_W       = 8,
    localparam int BANK_W     = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [1:0]                 req_cmd,
    input  logic [BANK_W-1:0]          req_bank,
    input  logic [ROW_W-1:0]           req_row,
    output logic                       req_accept,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] bank_row
);

    localparam int HALF = NUM_BANKS / 2;

    sbt_cmd_e                       cmd_e;
    sbt_bank_view_t [NUM_BANKS-1:0] views;
    logic [NUM_BANKS-1:0]           act_fire;
    logic [NUM_BANKS-1:0]           col_fire;
    logic [NUM_BANKS-1:0]           pre_fire;

    assign cmd_e = sbt_cmd_e'(req_cmd);

    sbt_rules #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) i_rules (
        .req_valid  (req_valid),
        .req_cmd    (cmd_e),
        .req_bank   (req_bank),
        .views      (views),
        .req_accept (req_accept),
        .act_fire   (act_fire),
        .col_fire   (col_fire),
        .pre_fire   (pre_fire)
    );

    for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
        sbt_bank #(
            .ROW_W       (ROW_W),
            .T_RCD       (T_RCD),
            .T_RAS       (T_RAS),
            .T_RP        (T_RP),
            .T_COL_EXTRA (T_COL_EXTRA),
            .FREE_COLS   (FREE_COLS),
            .CNT_W       (CNT_W)
        ) i_bank (
            .clk      (clk),
            .rst      (rst),
            .act_fire (act_fire[gb]),
            .col_fire (col_fire[gb]),
            .pre_fire (pre_fire[gb]),
            .row_in   (req_row),
            .view     (views[gb]),
            .row_q    (bank_row[gb*ROW_W +: ROW_W])
        );
        assign bank_open[gb] = views[gb].is_open;

        // R3: two banks sharing an amplifier are never open together
        if (has_upper_peer(gb, NUM_BANKS, HALF)) begin : g_excl
            a_r3_peers_exclusive: assert property (@(posedge clk) disable iff (rst)
                !(bank_open[gb] && bank_open[gb+1]));
        end
    end

    // R8: a rejected or absent request leaves the bank state alone
    a_r8_reject_holds: assert property (@(posedge clk) disable iff (rst)
        !req_accept |=> ($stable(bank_open) && $stable(bank_row)));

    // R2: at most one bank reacts to one request
    a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_fire | col_fire | pre_fire));

    // R1: the cycle after reset everything is closed
    a_r1_reset_closed: assert property (@(posedge clk)
        rst |=> (bank_open == '0));

endmodule

// File: tb/test_sbt_tracker.sv
`timescale 1ns/1ps
module test_sbt_tracker;

    localparam int NB    = 32;
    localparam int RW    = 9;
    localparam int TRCD  = 3;
    localparam int TRAS  = 8;
    localparam int TRP   = 4;
    localparam int TEXT  = 2;
    localparam int FREE  = 4;
    localparam int HALF  = NB / 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_cmd = 2'b00;
    logic [4:0]        req_bank = '0;
    logic [RW-1:0]     req_row = '0;
    logic              req_accept;
    logic [NB-1:0]     bank_open;
    logic [NB*RW-1:0]  bank_row;

    always #2 clk = ~clk;

    sbt_tracker #(
        .NUM_BANKS(NB), .ROW_W(RW), .T_RCD(TRCD), .T_RAS(TRAS), .T_RP(TRP),
        .T_COL_EXTRA(TEXT), .FREE_COLS(FREE), .CNT_W(8)
    ) i_sbt_tracker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_row(req_row), .req_accept(req_accept),
        .bank_open(bank_open), .bank_row(bank_row)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural reference
    int m_open [NB];
    int m_row  [NB];
    int m_act  [NB];
    int m_pre  [NB];
    int m_cols [NB];

    task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lo_open(input int b);
        if (b == 0 || b == HALF) return 0;
        return m_open[b-1];
    endfunction

    function automatic int hi_open(input int b);
        if (b == NB-1 || b == HALF-1) return 0;
        return m_open[b+1];
    endfunction

    function automatic bit model_accept(input bit v, input int cmd, input int b);
        int need;
        if (!v) return 0;
        need = TRAS + TEXT * ((m_cols[b] > FREE) ? (m_cols[b] - FREE) : 0);
        case (cmd)
            1: return (m_open[b] == 0) && (m_pre[b] >= TRP) && lo_open(b) == 0 && hi_open(b) == 0;
            2, 3: return (m_open[b] != 0) && (m_act[b] >= TRCD);
            default: return (m_open[b] != 0) && (m_act[b] >= need);
        endcase
    endfunction

    task automatic check_state(input string tag);
        logic [NB-1:0]    eo;
        logic [NB*RW-1:0] er;
        for (int b = 0; b < NB; b++) begin
            eo[b] = (m_open[b] != 0);
            er[b*RW +: RW] = m_row[b][RW-1:0];
        end
        check({tag, " open"}, 512'(bank_open), 512'(eo));
        check({tag, " row"},  512'(bank_row),  512'(er));
    endtask

    task automatic step(input bit v, input int cmd, input int b, input int row);
        bit    exp;
        string tag;
        @(negedge clk);
        req_valid = v;
        req_cmd   = cmd[1:0];
        req_bank  = b[4:0];
        req_row   = row[RW-1:0];
        #1;
        check_state("R8 R2");
        exp = model_accept(v, cmd, b);
        if (!v)             tag = "R9";
        else if (cmd == 1)  tag = "R2 R3 R4 R7";
        else if (cmd == 0)  tag = "R6";
        else                tag = "R5";
        check({tag, " accept"}, 512'(req_accept), 512'(exp));
        // model update for the coming edge
        for (int k = 0; k < NB; k++) begin
            if (m_act[k] < 1000000) m_act[k]++;
            if (m_pre[k] < 1000000) m_pre[k]++;
        end
        if (exp) begin
            if (cmd == 1) begin
                m_open[b] = 1; m_row[b] = row & 511; m_act[b] = 1; m_cols[b] = 0;
            end else if (cmd == 0) begin
                m_open[b] = 0; m_pre[b] = 1;
            end else begin
                m_cols[b]++;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 1, 0, 0);
    endtask

    // Retry a command every cycle until accepted (bounded)
    task automatic until_ok(input int cmd, input int b, input int row);
        for (int i = 0; i < 40; i++) begin
            bit ok;
            ok = model_accept(1, cmd, b);
            step(1, cmd, b, row);
            if (ok) break;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_open[b] = 0; m_row[b] = 0; m_act[b] = 1000000; m_pre[b] = 1000000; m_cols[b] = 0;
        end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset open", 512'(bank_open), 512'(0));
        check("R1 reset row",  512'(bank_row),  512'(0));

        // R1/R2: immediate activate after reset
        step(1, 1, 5, 'h1A3);
        // R3/R4: neighbours and self blocked
        step(1, 1, 4, 7);
        step(1, 1, 6, 7);
        step(1, 1, 5, 9);
        // R9: valid low with activate code
        step(0, 1, 9, 3);
        // R5: column tried every cycle until the earliest legal one
        until_ok(2, 5, 0);
        // R5: column to closed bank
        step(1, 3, 20, 0);
        // R6: precharge of closed bank
        step(1, 0, 20, 0);
        // R6: precharge retried until legal
        until_ok(0, 5, 0);
        // R7: reactivate retried until precharge time has passed
        until_ok(1, 5, 'h055);
        until_ok(0, 5, 0);

        // R6: stretched precharge after many columns
        until_ok(1, 10, 'h111);
        for (int i = 0; i < 7; i++) until_ok(3, 10, 0);
        until_ok(0, 10, 0);

        // R3: edge cases 0/1, 15/16, 30/31
        until_ok(1, 0, 'h0AA);
        step(1, 1, 1, 1);
        until_ok(1, 15, 'h0F0);
        step(1, 1, 16, 'h10F);
        step(1, 1, 14, 2);
        step(1, 1, 17, 2);
        until_ok(1, 31, 'h1FF);
        step(1, 1, 30, 3);
        idle(10);
        for (int b = 0; b < NB; b++) if (m_open[b] != 0) until_ok(0, b, 0);
        idle(5);

        // Random phase with conflicts concentrated on low banks
        for (int i = 0; i < 4000; i++) begin
            int b;
            b = ($urandom_range(0, 3) == 0) ? int'($urandom_range(12, 19)) : int'($urandom_range(0, 7));
            step($urandom_range(0, 7) != 0, int'($urandom_range(0, 3)), b, int'($urandom_range(0, 511)));
        end
        idle(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule